// File: doc/BRIEF.md
# Masked Interrupt Event Aggregator

This block collects thirteen interrupt-worthy events into a 32-bit event register. Internal sources raise an event by pulsing its set bit for one cycle. Software enables events through a 32-bit mask register and acknowledges them by writing ones back to the event register. The block does not merge the enabled events into one request. Each of thirteen separate interrupt lines follows one event bit through a fixed, scattered mapping, so the interrupt controller further up can route every cause on its own.

Event bits sit in the upper part of the register, bits 31 down to 19: bit 31 heartbeat, 30 babbling receive, 29 babbling transmit, 28 graceful stop done, 27 transmit frame, 26 transmit buffer, 25 receive frame, 24 receive buffer, 23 management done, 22 bus error, 21 late collision, 20 retry limit, 19 underrun. A registered copy of the enabled events drives the output lines, so every line is a flop output.

Top module: `evt_irq_hub`

## Requirements
- R1: While reset is asserted, and right after it is released, the event register, the mask register and all interrupt lines read zero.
- R2: A one on `evtSet[k]` for k in 31..19 makes event bit k read one from the next cycle on, and the bit stays set until software clears it.
- R3: A write with `regAddr`=0 clears every event bit whose `regWrData` bit is one and leaves the bits written as zero unchanged.
- R4: A write with `regAddr`=1 replaces all 32 mask bits with `regWrData`, and a read with `regAddr`=1 returns the stored mask.
- R5: When a set pulse and a software clear hit the same event bit in the same cycle, the bit ends up set.
- R6: Event bits 18..0 always read zero. Set pulses and writes on those positions have no effect.
- R7: Interrupt line i is the AND of one event bit and the same mask bit. Lines 0 to 12 use event bits 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30 in that order.
- R8: An interrupt line changes exactly one clock after the change in the event or mask register that causes it.
- R9: `regRdData` shows the event register when `regAddr`=0 and the mask register when `regAddr`=1, in the same cycle, with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evtSet | input | 32 | One-cycle set pulses from the event sources, one per event bit |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 event, 1 mask |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the selected register |
| irqLines | output | 13 | Registered interrupt lines |

## Verification
The bench drives every line by itself in turn. A design with a wrong or shifted line mapping would raise a neighbouring line instead of the expected one. A set pulse and a one-to-clear on the same bit in the same cycle separate a design where the set wins from one where the clear wins and drops the event. Writes and set pulses on the reserved low bits show whether the design stores bits it should ignore. The bench also samples the lines in the cycle between a mask write and the line change, which exposes lines that are combinational or one cycle late. A long pseudo-random run checks overlapping sets, clears and mask changes against the model on every clock.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  localparam int DATA_W    = 32;
  localparam int NUM_LINES = 13;
  localparam int EVT_LSB   = 19;

  typedef struct packed {
    logic              clrEvt;
    logic              ldMask;
    logic [DATA_W-1:0] data;
  } regStrobe_t;

  // event bit feeding each interrupt line
  function automatic int lineSrc(input int line);
    case (line)
      0:       return 27;
      1:       return 26;
      2:       return 19;
      3:       return 20;
      4:       return 25;
      5:       return 24;
      6:       return 23;
      7:       return 21;
      8:       return 31;
      9:       return 28;
      10:      return 22;
      11:      return 29;
      default: return 30;
    endcase
  endfunction

endpackage

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          regWrEn,
  input  logic          regAddr,
  input  logic [DW-1:0] regWrData,
  input  logic [DW-1:0] evtVal,
  input  logic [DW-1:0] maskVal,
  output regStrobe_t    strb,
  output logic [DW-1:0] regRdData
);

  always_comb begin
    strb.clrEvt = regWrEn & ~regAddr;
    strb.ldMask = regWrEn & regAddr;
    strb.data   = regWrData;
  end

  assign regRdData = regAddr ? maskVal : evtVal;

endmodule

// File: rtl/evt_irq_dp.sv
module evt_irq_dp
  import evt_irq_pkg::*;
#(
  parameter int DW     = DATA_W,
  parameter int NLINES = NUM_LINES,
  parameter int LSB    = EVT_LSB
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [DW-1:0]     evtSet,
  output logic [DW-1:0]     evtVal,
  output logic [DW-1:0]     maskVal,
  output logic [NLINES-1:0] irqLines
);

  localparam logic [DW-1:0] KEEP = {DW{1'b1}} << LSB;

  logic [DW-1:0]     evtQ, maskQ, evtNext, clrVec;
  logic [NLINES-1:0] activeQ;

  assign clrVec  = strb.clrEvt ? strb.data : '0;
  // set is ORed in after the clear, so it wins on a collision
  assign evtNext = ((evtQ & ~clrVec) | evtSet) & KEEP;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtQ  <= '0;
      maskQ <= '0;
    end else begin
      evtQ <= evtNext;
      if (strb.ldMask) maskQ <= strb.data;
    end
  end

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    localparam int SRC = lineSrc(g);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) activeQ[g] <= 1'b0;
      else       activeQ[g] <= evtQ[SRC] & maskQ[SRC];
    end
  end

  assign evtVal   = evtQ;
  assign maskVal  = maskQ;
  assign irqLines = activeQ;

endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
  import evt_irq_pkg::*;
#(
  parameter int DW     = DATA_W,
  parameter int NLINES = NUM_LINES,
  parameter int LSB    = EVT_LSB
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DW-1:0]     evtSet,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DW-1:0]     regWrData,
  output logic [DW-1:0]     regRdData,
  output logic [NLINES-1:0] irqLines
);

  regStrobe_t    strb;
  logic [DW-1:0] evtVal, maskVal;

  evt_irq_ctrl #(.DW(DW)) u_ctrl (
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .evtVal    (evtVal),
    .maskVal   (maskVal),
    .strb      (strb),
    .regRdData (regRdData)
  );

  evt_irq_dp #(.DW(DW), .NLINES(NLINES), .LSB(LSB)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .evtSet   (evtSet),
    .evtVal   (evtVal),
    .maskVal  (maskVal),
    .irqLines (irqLines)
  );

endmodule

// File: rtl/evt_irq_hub_chk.sv
module evt_irq_hub_chk
  import evt_irq_pkg::*;
#(
  parameter int DW     = DATA_W,
  parameter int NLINES = NUM_LINES,
  parameter int LSB    = EVT_LSB
) (
  input logic              clk,
  input logic              rstN,
  input logic [DW-1:0]     evtSet,
  input logic              regWrEn,
  input logic              regAddr,
  input logic [DW-1:0]     regWrData,
  input logic [DW-1:0]     evtVal,
  input logic [DW-1:0]     maskVal,
  input logic [NLINES-1:0] irqLines
);

  localparam logic [DW-1:0] KEEP = {DW{1'b1}} << LSB;

  // R2
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtSet & KEEP) != '0 |=> (evtVal & $past(evtSet & KEEP)) == $past(evtSet & KEEP));

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regAddr) |=> (evtVal & $past(regWrData) & ~$past(evtSet)) == '0);

  // R4
  mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr) |=> maskVal == $past(regWrData));

  // R5
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regAddr && (evtSet & regWrData & KEEP) != '0)
      |=> (evtVal & $past(evtSet & regWrData & KEEP)) == $past(evtSet & regWrData & KEEP));

  // R6
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtVal[LSB-1:0] == '0);

  for (genvar g = 0; g < NLINES; g++) begin : g_lchk
    localparam int SRC = lineSrc(g);
    // R8
    line_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
      irqLines[g] == $past(evtVal[SRC] & maskVal[SRC]));
  end

endmodule

bind evt_irq_hub evt_irq_hub_chk #(.DW(DW), .NLINES(NLINES), .LSB(LSB)) chk (
  .clk       (clk),
  .rstN      (rstN),
  .evtSet    (evtSet),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .evtVal    (evtVal),
  .maskVal   (maskVal),
  .irqLines  (irqLines)
);

// File: tb/evt_irq_hub_test.sv
module evt_irq_hub_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] evtSet = '0;
  logic        regWrEn = 1'b0;
  logic        regAddr = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [12:0] irqLines;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int lineMap [13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};

  // reference model state
  logic [31:0] mEvt = '0, mMask = '0;
  logic [12:0] mLines = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_irq_hub uut (
    .clk(clk), .rstN(rstN), .evtSet(evtSet), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqLines(irqLines)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mEvt = '0; mMask = '0; mLines = '0;
    end else begin
      for (int i = 0; i < 13; i++) mLines[i] = mEvt[lineMap[i]] & mMask[lineMap[i]];
      if (regWrEn && !regAddr) mEvt = mEvt & ~regWrData;
      mEvt = (mEvt | evtSet) & 32'hFFF8_0000;
      if (regWrEn && regAddr) mMask = regWrData;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // compare against the model, then drive the next inputs
  task automatic cyc(input logic [31:0] s, input logic we, input logic a, input logic [31:0] d);
    @(negedge clk);
    check("R9 readback", regRdData, a_model());
    check("R7 line vector", {19'd0, irqLines}, {19'd0, mLines});
    evtSet = s; regWrEn = we; regAddr = a; regWrData = d;
  endtask

  function automatic logic [31:0] a_model();
    return regAddr ? mMask : mEvt;
  endfunction

  task automatic idle(input logic a);
    cyc('0, 1'b0, a, '0);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD*WATCHDOG);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 event in reset", regRdData, 32'h0);
    check("R1 lines in reset", {19'd0, irqLines}, 32'h0);
    rstN = 1'b1;
    idle(1'b1);
    check("R1 mask after reset", regRdData, 32'h0);

    // R2 single set pulse, mask still zero
    cyc(32'h0800_0000, 1'b0, 1'b0, '0);
    idle(1'b0);
    check("R2 set pulse", regRdData, 32'h0800_0000);
    idle(1'b0);
    check("R2 bit stays set", regRdData, 32'h0800_0000);
    check("R7 masked line low", {19'd0, irqLines}, 32'h0);

    // R4 mask write and R8 latency
    cyc('0, 1'b1, 1'b1, 32'hFFFF_FFFF);
    idle(1'b1);
    check("R4 mask readback", regRdData, 32'hFFFF_FFFF);
    check("R8 line not yet", {19'd0, irqLines}, 32'h0);
    idle(1'b0);
    check("R8 line after one clock", {19'd0, irqLines}, 32'h1);

    // R6 set on all positions
    cyc(32'hFFFF_FFFF, 1'b0, 1'b0, '0);
    idle(1'b0);
    check("R6 reserved set ignored", regRdData, 32'hFFF8_0000);

    // R3 write one to clear
    cyc('0, 1'b1, 1'b0, 32'h0800_0000);
    idle(1'b0);
    check("R3 w1c", regRdData, 32'hF7F8_0000);

    // R5 collision
    cyc(32'h1000_0000, 1'b1, 1'b0, 32'h1000_0000);
    idle(1'b0);
    check("R5 set wins", regRdData, 32'hF7F8_0000);

    // R6 writes on reserved bits
    cyc('0, 1'b1, 1'b0, 32'h0007_FFFF);
    idle(1'b0);
    check("R6 reserved write ignored", regRdData, 32'hF7F8_0000);

    // R7 each line alone
    cyc('0, 1'b1, 1'b0, 32'hFFFF_FFFF);
    idle(1'b0);
    idle(1'b0);
    for (int i = 0; i < 13; i++) begin
      cyc(32'h1 << lineMap[i], 1'b0, 1'b0, '0);
      idle(1'b0);
      idle(1'b0);
      check("R7 mapped line", {19'd0, irqLines}, 32'h1 << i);
      cyc('0, 1'b1, 1'b0, 32'hFFFF_FFFF);
    end

    // mixed random traffic, model compared every clock (R2 R3 R4 R5 R7 R8)
    lfsr = 32'hACE1_2345;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      cyc(lfsr[3] ? (lfsr ^ 32'h5A5A_0000) : '0, lfsr[9] & lfsr[4], lfsr[17],
          {lfsr[15:0], lfsr[31:16]});
    end
    idle(1'b0);
    idle(1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule